// File: doc/BRIEF.md
# Hysteretic PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches two slow edge streams, the divided reference clock and the divided feedback clock, as they would reach a phase-frequency detector. Both pass through synchronizers clocked by a fast sampling clock. For every comparison cycle the block counts the sampling-clock ticks between the edge that arrives first and the edge that arrives second. That tick count is the phase error.

An active-high lock flag rises after a run of consecutive cycles whose error is below a programmable lock threshold. Once the flag is high, only a single cycle with an error at or above a larger unlock threshold clears it. The gap between the two thresholds gives hysteresis, so the flag does not chatter while the loop sits near its noise floor.

If one edge arrives and its partner does not follow within a timeout, that cycle counts as a large error. Both thresholds are ports, so software or a neighbouring block can set them in tick units for the sampling clock in use.

Top module: `pll_lock_detect`

## Requirements
- R1: `lock_o` is high when locked and low otherwise. Reset (`rst_n` low) forces `lock_o` low and clears the run of good cycles, so a full new run is needed after reset.
- R2: The phase error is the number of sampling-clock ticks between the synchronized rising edge that arrives first and the one that arrives second. Either input may lead. Edges captured on the same tick give an error of 0.
- R3: A cycle is small when its error is strictly below `lock_thr`; an error equal to `lock_thr` is not small. While unlocked, `LOCK_RUN` (default 5) consecutive small cycles raise `lock_o`. It changes on the third rising `clk` edge after the edge that first samples the second input high.
- R4: While unlocked, any cycle that is not small restarts the run from zero.
- R5: While locked, a cycle whose error is below `unlock_thr` leaves `lock_o` high, even when the error is at or above `lock_thr`.
- R6: While locked, a single cycle with an error at or above `unlock_thr` drops `lock_o`, and the next lock needs a full new run.
- R7: If the partner edge has not arrived `TIMEOUT` ticks (default 100) after the first edge, the cycle ends as a large error. A partner that arrives exactly on the timeout tick ends the cycle as a normal measurement of `TIMEOUT` ticks.
- R8: The thresholds are read when each measurement completes, so new values on `lock_thr` and `unlock_thr` govern the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Divided reference clock, asynchronous |
| fb_in | input | 1 | Divided feedback clock, asynchronous |
| lock_thr | input | CNT_W | Error in ticks below which a cycle counts as small |
| unlock_thr | input | CNT_W | Error in ticks at or above which a locked detector drops lock |
| lock_o | output | 1 | Lock flag, active high |

## Verification
Two functions can fall on the same tick: the timeout expiring and the partner edge arriving. The bench provokes this by delaying the feedback edge by exactly `TIMEOUT` ticks while the detector is locked. The partner is then taken as a measurement rather than a timeout, and the result must be judged large. Coincident edges on both inputs are the second overlap: the arrival-order logic must produce a zero error and not start a wait. A behavioural model follows every cycle and, together with directed checks at the threshold boundaries, judges both cases.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic {
    MT_IDLE = 1'b0,
    MT_WAIT = 1'b1
  } meter_st_e;

  // A completed comparison counts toward lock only when it measured a
  // real edge pair and the error is strictly below the lock threshold.
  function automatic logic err_is_small(input logic tout,
                                        input int unsigned err,
                                        input int unsigned thr);
    return !tout && (err < thr);
  endfunction

  // A timed-out comparison, or one at or past the unlock threshold, is large.
  function automatic logic err_is_large(input logic tout,
                                        input int unsigned err,
                                        input int unsigned thr);
    return tout || (err >= thr);
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[DEPTH-2:0], async_in};
  end

  // The last stage only delays the synchronized level for edge detection.
  assign rise_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R2: a synchronized rise is seen on exactly one tick.
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/phase_meter.sv
module phase_meter
  import lockdet_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TIMEOUT = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic             meas_vld,
  output logic             meas_tout,
  output logic [CNT_W-1:0] meas_err
);

  localparam logic [CNT_W-1:0] TMO_C = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  meter_st_e        st_q;
  logic             ref_first_q;
  logic [CNT_W-1:0] cnt_q;

  // Named internal events, kept for the assertions below.
  logic both_now;
  logic one_now;
  logic partner_now;
  logic expire_now;

  assign both_now    = (st_q == MT_IDLE) && ref_pulse && fb_pulse;
  assign one_now     = (st_q == MT_IDLE) && (ref_pulse ^ fb_pulse);
  assign partner_now = (st_q == MT_WAIT) && (ref_first_q ? fb_pulse : ref_pulse);
  assign expire_now  = (st_q == MT_WAIT) && !partner_now && (cnt_q == TMO_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= MT_IDLE;
      ref_first_q <= 1'b0;
      cnt_q       <= '0;
      meas_vld    <= 1'b0;
      meas_tout   <= 1'b0;
      meas_err    <= '0;
    end else begin
      meas_vld  <= 1'b0;
      meas_tout <= 1'b0;
      if (both_now) begin
        meas_vld <= 1'b1;
        meas_err <= '0;
      end else if (one_now) begin
        st_q        <= MT_WAIT;
        ref_first_q <= ref_pulse;
        cnt_q       <= ONE_C;
      end else if (partner_now) begin
        st_q     <= MT_IDLE;
        meas_vld <= 1'b1;
        meas_err <= cnt_q;
      end else if (expire_now) begin
        st_q      <= MT_IDLE;
        meas_vld  <= 1'b1;
        meas_tout <= 1'b1;
        meas_err  <= TMO_C;
      end else if (st_q == MT_WAIT) begin
        cnt_q <= cnt_q + ONE_C;
      end
    end
  end

  // R2: coincident edges yield a zero-error result on the next tick.
  p_coincident_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    both_now |=> (meas_vld && !meas_tout && meas_err == '0));

  // R2: a measured error never exceeds the timeout window.
  p_err_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |-> (meas_err <= TMO_C));

  // R7: a timeout result carries the saturated error.
  p_tout_saturates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && meas_tout) |-> (meas_err == TMO_C));

  // R7: the wait counter stays inside its window.
  p_wait_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MT_WAIT) |-> (cnt_q >= ONE_C && cnt_q <= TMO_C));

  // R7: a partner arriving on the expiry tick wins over the timeout.
  p_partner_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (partner_now && cnt_q == TMO_C) |=> (meas_vld && !meas_tout));

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lockdet_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LOCK_RUN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_vld,
  input  logic             meas_tout,
  input  logic [CNT_W-1:0] meas_err,
  input  logic [CNT_W-1:0] lock_thr,
  input  logic [CNT_W-1:0] unlock_thr,
  output logic             lock_o
);

  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_C = RUN_W'(LOCK_RUN);
  localparam logic [RUN_W-1:0] ONE_R = RUN_W'(1);

  logic             lock_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_inc;
  logic             cyc_small;
  logic             cyc_large;
  logic             run_done;

  assign cyc_small = meas_vld && err_is_small(meas_tout, 32'(meas_err), 32'(lock_thr));
  assign cyc_large = meas_vld && err_is_large(meas_tout, 32'(meas_err), 32'(unlock_thr));
  assign run_inc   = run_q + ONE_R;
  assign run_done  = cyc_small && (run_inc == RUN_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (meas_vld) begin
      if (lock_q) begin
        if (cyc_large) begin
          lock_q <= 1'b0;
          run_q  <= '0;
        end
      end else if (run_done) begin
        lock_q <= 1'b1;
        run_q  <= '0;
      end else if (cyc_small) begin
        run_q <= run_inc;
      end else begin
        run_q <= '0;
      end
    end
  end

  assign lock_o = lock_q;

  // R1: the flag is low on the tick after reset is seen.
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> !lock_q);

  // R3: the flag rises only right after a small comparison.
  p_rise_after_small_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(cyc_small));

  // R4: the run counter never reaches the lock count.
  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RUN_C);

  // R5: a locked flag survives any comparison that is not large.
  p_hold_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !cyc_large) |=> lock_q);

  // R6: the flag falls only right after a large comparison.
  p_fall_after_large_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(cyc_large));

  // R6: while locked, the run is held at zero for the next attempt.
  p_run_idle_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (run_q == '0));

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int CNT_W       = 8,
  parameter int TIMEOUT     = 100,
  parameter int LOCK_RUN    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [CNT_W-1:0] lock_thr,
  input  logic [CNT_W-1:0] unlock_thr,
  output logic             lock_o
);

  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] rise;
  logic              meas_vld;
  logic              meas_tout;
  logic [CNT_W-1:0]  meas_err;

  assign raw_in = {fb_in, ref_in};

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_in  (raw_in[gi]),
      .rise_pulse(rise[gi])
    );
  end

  phase_meter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_pulse(rise[0]),
    .fb_pulse (rise[1]),
    .meas_vld (meas_vld),
    .meas_tout(meas_tout),
    .meas_err (meas_err)
  );

  lock_fsm #(.CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .meas_vld  (meas_vld),
    .meas_tout (meas_tout),
    .meas_err  (meas_err),
    .lock_thr  (lock_thr),
    .unlock_thr(unlock_thr),
    .lock_o    (lock_o)
  );

  initial begin
    if (TIMEOUT >= (1 << CNT_W) || TIMEOUT < 1) $error("TIMEOUT must fit CNT_W");
    if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
  end

endmodule

// File: tb/pll_lock_detect_tb.sv
`timescale 1ns/1ps
module pll_lock_detect_tb;

  localparam int CNT_W = 8;
  localparam int TMO   = 100;
  localparam int RUN   = 5;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_d = 1'b0;
  logic fb_d = 1'b0;
  logic [CNT_W-1:0] lthr = 8'd4;
  logic [CNT_W-1:0] uthr = 8'd7;
  logic lock_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int wd = 0;

  always #2 clk = ~clk;

  pll_lock_detect u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_d), .fb_in(fb_d),
    .lock_thr(lthr), .unlock_thr(uthr), .lock_o(lock_o)
  );

  // Behavioural reference model, one step per sampling tick.
  int  cyc, t0, err;
  bit  pend, pend_ref, tout, got, pr, pf, rr, fr, mlock;
  int  run;
  bit  hist[LAT+1];

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; pend = 0; pr = 0; pf = 0; mlock = 0; run = 0;
      foreach (hist[i]) hist[i] = 1'b0;
    end else begin
      cyc++;
      rr = ref_d && !pr;
      fr = fb_d && !pf;
      pr = ref_d;
      pf = fb_d;
      got = 0;
      tout = 0;
      if (pend) begin
        if ((pend_ref && fr) || (!pend_ref && rr)) begin
          got = 1; err = cyc - t0; pend = 0;
        end else if (cyc - t0 == TMO) begin
          got = 1; tout = 1; err = TMO; pend = 0;
        end
      end else if (rr && fr) begin
        got = 1; err = 0;
      end else if (rr || fr) begin
        pend = 1; pend_ref = rr; t0 = cyc;
      end
      if (got) begin
        if (mlock) begin
          if (tout || err >= int'(uthr)) begin mlock = 0; run = 0; end
        end else if (!tout && err < int'(lthr)) begin
          run++;
          if (run == RUN) begin mlock = 1; run = 0; end
        end else begin
          run = 0;
        end
      end
      for (int i = LAT; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = mlock;
    end
  end

  // Model comparison on every tick (R2 arrival timing through R6 state).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (lock_o !== hist[LAT]) begin
        n_fail++;
        $display("FAIL R2 model cycle %0d: lock_o=%0b expected=%0b", cyc, lock_o, hist[LAT]);
      end
    end
  end

  task automatic chk(input string tag, input logic exp);
    n_chk++;
    if (lock_o !== exp) begin
      n_fail++;
      $display("FAIL %s: lock_o=%0b expected=%0b", tag, lock_o, exp);
    end
  endtask

  task automatic pair(input bit ref_lead, input int gap);
    @(negedge clk);
    if (gap == 0) begin
      ref_d = 1'b1; fb_d = 1'b1;
    end else begin
      if (ref_lead) ref_d = 1'b1; else fb_d = 1'b1;
      repeat (gap) @(negedge clk);
      if (ref_lead) fb_d = 1'b1; else ref_d = 1'b1;
    end
    repeat (4) @(negedge clk);
    ref_d = 1'b0; fb_d = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic pairs(input int n, input int gap);
    for (int i = 0; i < n; i++) pair(1'b1, gap);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset low", 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", 1'b0);

    pairs(5, 4);
    chk("R3 error equal to lock_thr is not small", 1'b0);
    pairs(4, 2);
    chk("R3 four small cycles", 1'b0);
    pair(1'b1, 0);
    chk("R3 fifth small cycle (R2 coincident edges)", 1'b1);

    pair(1'b0, 6);
    chk("R5 feedback leads, error just under unlock_thr", 1'b1);
    pair(1'b0, 7);
    chk("R6 feedback leads, error at unlock_thr", 1'b0);

    pairs(3, 1);
    pair(1'b1, 5);
    chk("R4 run broken by mid error", 1'b0);
    pairs(4, 3);
    chk("R4 four after restart", 1'b0);
    pair(1'b0, 3);
    chk("R4 fifth after restart", 1'b1);

    pair(1'b1, 5);
    chk("R5 mid error keeps lock", 1'b1);

    @(negedge clk);
    ref_d = 1'b1;
    repeat (120) @(negedge clk);
    ref_d = 1'b0;
    repeat (12) @(negedge clk);
    chk("R7 missing partner drops lock", 1'b0);

    pairs(5, 2);
    chk("R7 relock before expiry overlap", 1'b1);
    pair(1'b1, TMO);
    chk("R7 partner on expiry tick is large", 1'b0);

    lthr = 8'd8; uthr = 8'd12;
    repeat (4) @(negedge clk);
    pairs(5, 6);
    chk("R8 raised lock_thr admits gap 6", 1'b1);
    pair(1'b0, 10);
    chk("R8 gap 10 below raised unlock_thr", 1'b1);
    pair(1'b1, 12);
    chk("R8 gap 12 at raised unlock_thr", 1'b0);

    pairs(5, 6);
    chk("R1 locked before reset", 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset clears lock", 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pairs(4, 6);
    chk("R1 run cleared by reset", 1'b0);
    pair(1'b1, 6);
    chk("R1 full run after reset", 1'b1);

    finish_run();
  end

endmodule